// File: doc/BRIEF.md
# Indirect Internal Register Bridge

This block connects a 32-bit host register port to a small bank of 16-bit internal control registers. The internal bank is not mapped into the host space. The host reaches it through three host-visible words: a data window, an address window and a status word. A host write to the address window starts one internal access. The access is a write when the write flag in that word is set, and a read when the flag is clear. The access then runs for a fixed number of clock cycles, and the status word reports it as busy for that whole time.

For a write, software first places the 16-bit value in the data window. It then writes the target index with the write flag set, and the bank takes the latched value when the access completes. For a read, software writes the index with the flag clear and polls until busy drops. The register value is then present in the data window.

The bank holds a mode register, a receive/transmit control register and three station-address registers. These drive the datapath directly. The three station registers are laid out so that the 48-bit address reads big-endian across them.

Top module: `ireg_bridge`

## Requirements
- R1: After reset the data window reads 0, busy is 0, the control register, all three station registers and `station_addr` are 0. Host offsets are: 0 = data window, 1 = address window, 2 = status (bit 0 = busy).
- R2: A host write to offset 1 while idle raises busy on the next clock edge. Busy then stays high for exactly ACCESS_CYCLES clock cycles (default 8), after which it falls.
- R3: When the accepted address word has bit 31 set, the access is a write. The low 16 bits of the data window are stored into the internal register named by bits 4:0, and only at the cycle busy falls. The data window keeps only bits 15:0 of a host write and reads 0 in bits 31:16.
- R4: When bit 31 of the accepted address word is clear, the access is a read. When busy falls, the data window reads `{16'h0, value}` of the indexed register.
- R5: Address-window writes made while busy are ignored. They neither restart the access nor change its target or direction.
- R6: Data-window writes made while busy are ignored, so a read result cannot be overwritten by an early host write.
- R7: Internal indices other than 0, 1, 4, 5 and 6 read as 0, and writes to them change no register.
- R8: The station registers sit at indices 4, 5 and 6. Octet 0 of `station_addr` (bits 47:40) is the high byte of index 4, and octet 1 is its low byte. Octets 2–3 come from index 5 and octets 4–5 from index 6 in the same way.
- R9: The mode register sits at index 0. It resets to 0x0008: bit 3 (flow control) is set, and bits 0 (receive enable), 1 (transmit enable) and 2 (gigabit) are clear. The control register sits at index 1.
- R10: Offset 1 reads back the last accepted address word as `{write flag, 26'h0, index}`. Offset 2 bit 0 is 1 exactly while an access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | Host write (1) or read (0) |
| host_addr | input | 2 | Host word offset |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (combinational on offset) |
| busy | output | 1 | Internal access in progress |
| station_addr | output | 48 | Station address, octet 0 in bits 47:40 |
| mode_bits | output | 16 | Mode register contents |
| ctrl_bits | output | 16 | Receive/transmit control register contents |

## Verification
The hardest conditions to reach are host writes that land inside the busy window, because they must leave no trace. The bench starts a read and, a few cycles into the access, issues a write-flagged address word aimed at the control register and a data-window write. It then checks three things: busy lasted exactly the original latency, the control register is unchanged, and the data window carries the register being read. A committed write is also observed mid-access, to show that the target changes only when busy falls.

// File: rtl/ireg_bridge_pkg.sv
package ireg_bridge_pkg;

    localparam int HOST_OFF_W = 2;
    localparam int IDX_W      = 5;
    localparam int IREG_W     = 16;
    localparam int HOST_W     = 32;
    localparam int WFLAG_BIT  = 31;
    localparam int STA_REGS   = 3;

    typedef enum logic [HOST_OFF_W-1:0] {
        HOFF_DATA = 2'd0,
        HOFF_ADDR = 2'd1,
        HOFF_STAT = 2'd2
    } host_off_e;

    localparam logic [IDX_W-1:0] IDX_MODE = 5'd0;
    localparam logic [IDX_W-1:0] IDX_CTRL = 5'd1;
    localparam logic [IDX_W-1:0] IDX_STA0 = 5'd4;

    localparam logic [IREG_W-1:0] MODE_RESET = 16'h0008;

    typedef struct packed {
        logic [IREG_W-1:0] mode;
        logic [IREG_W-1:0] ctrl;
        logic [STA_REGS-1:0][IREG_W-1:0] sta;
    } bank_t;

endpackage

// File: rtl/ireg_access_timer.sv
module ireg_access_timer #(
    parameter int LAT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic fire
);
    localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LAT - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            if (s_q.cnt == '0) s_d.busy = 1'b0;
            else               s_d.cnt  = s_q.cnt - 1'b1;
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_LOAD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign fire = s_q.busy && (s_q.cnt == '0);

    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R2
    AST_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !busy); // R2
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fire) |=> (busy && s_q.cnt == $past(s_q.cnt) - 1'b1)); // R5

endmodule

// File: rtl/ireg_bank.sv
module ireg_bank
    import ireg_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [IREG_W-1:0] wdata,
    output logic [IREG_W-1:0] rd_data,
    output logic [IREG_W-1:0] mode_bits,
    output logic [IREG_W-1:0] ctrl_bits,
    output logic [8*2*STA_REGS-1:0] station_addr
);
    bank_t b_d, b_q;
    logic  defined;

    always_comb begin
        b_d     = b_q;
        rd_data = '0;
        defined = 1'b0;
        if (idx == IDX_MODE) begin
            rd_data = b_q.mode;
            defined = 1'b1;
            if (wr_en) b_d.mode = wdata;
        end
        if (idx == IDX_CTRL) begin
            rd_data = b_q.ctrl;
            defined = 1'b1;
            if (wr_en) b_d.ctrl = wdata;
        end
        for (int i = 0; i < STA_REGS; i++) begin
            if (idx == IDX_STA0 + IDX_W'(i)) begin
                rd_data = b_q.sta[i];
                defined = 1'b1;
                if (wr_en) b_d.sta[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q      <= '0;
            b_q.mode <= MODE_RESET;
        end else begin
            b_q <= b_d;
        end
    end

    assign mode_bits = b_q.mode;
    assign ctrl_bits = b_q.ctrl;

    // Station register g feeds octets 2g (high byte) and 2g+1 (low byte).
    for (genvar g = 0; g < STA_REGS; g++) begin : g_sta
        assign station_addr[8*2*STA_REGS-1-IREG_W*g -: IREG_W] = b_q.sta[g];
    end

    AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(b_q)); // R3
    AST_UNDEF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !defined) |=> $stable(b_q)); // R7

endmodule

// File: rtl/ireg_host_if.sv
module ireg_host_if
    import ireg_bridge_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_sel,
    input  logic                  host_we,
    input  logic [HOST_OFF_W-1:0] host_addr,
    input  logic [HOST_W-1:0]     host_wdata,
    output logic [HOST_W-1:0]     host_rdata,
    input  logic                  busy,
    input  logic                  fire,
    input  logic [IREG_W-1:0]     rd_data,
    output logic                  start,
    output logic                  bank_we,
    output logic [IDX_W-1:0]      idx,
    output logic [IREG_W-1:0]     wdata
);
    typedef struct packed {
        logic [IREG_W-1:0] data;
        logic [IDX_W-1:0]  idx;
        logic              wflag;
    } win_t;

    win_t w_d, w_q;
    logic host_wr;

    assign host_wr = host_sel && host_we;
    assign start   = host_wr && (host_addr == HOFF_ADDR) && !busy;

    always_comb begin
        w_d = w_q;
        if (start) begin
            w_d.idx   = host_wdata[IDX_W-1:0];
            w_d.wflag = host_wdata[WFLAG_BIT];
        end
        if (host_wr && (host_addr == HOFF_DATA) && !busy)
            w_d.data = host_wdata[IREG_W-1:0];
        if (fire && !w_q.wflag)
            w_d.data = rd_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    always_comb begin
        host_rdata = '0;
        case (host_addr)
            HOFF_DATA: host_rdata[IREG_W-1:0] = w_q.data;
            HOFF_ADDR: begin
                host_rdata[IDX_W-1:0]  = w_q.idx;
                host_rdata[WFLAG_BIT]  = w_q.wflag;
            end
            HOFF_STAT: host_rdata[0] = busy;
            default:   host_rdata = '0;
        endcase
    end

    assign bank_we = fire && w_q.wflag;
    assign idx     = w_q.idx;
    assign wdata   = w_q.data;

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fire) |=> $stable(w_q.data)); // R6
    AST_TARGET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({w_q.idx, w_q.wflag})); // R5

endmodule

// File: rtl/ireg_bridge.sv
module ireg_bridge
    import ireg_bridge_pkg::*;
#(
    parameter int ACCESS_CYCLES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_sel,
    input  logic        host_we,
    input  logic [1:0]  host_addr,
    input  logic [31:0] host_wdata,
    output logic [31:0] host_rdata,
    output logic        busy,
    output logic [47:0] station_addr,
    output logic [15:0] mode_bits,
    output logic [15:0] ctrl_bits
);
    logic              start, fire, bank_we;
    logic [IDX_W-1:0]  idx;
    logic [IREG_W-1:0] wdata, rd_data;

    ireg_host_if u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .busy       (busy),
        .fire       (fire),
        .rd_data    (rd_data),
        .start      (start),
        .bank_we    (bank_we),
        .idx        (idx),
        .wdata      (wdata)
    );

    ireg_access_timer #(.LAT(ACCESS_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .busy  (busy),
        .fire  (fire)
    );

    ireg_bank u_bank (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (bank_we),
        .idx          (idx),
        .wdata        (wdata),
        .rd_data      (rd_data),
        .mode_bits    (mode_bits),
        .ctrl_bits    (ctrl_bits),
        .station_addr (station_addr)
    );

endmodule

// File: tb/ireg_bridge_bench.sv
module ireg_bridge_bench;
    localparam int LAT = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        busy;
    logic [47:0] station_addr;
    logic [15:0] mode_bits, ctrl_bits;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ireg_bridge #(.ACCESS_CYCLES(LAT)) u_ireg_bridge (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .busy(busy), .station_addr(station_addr), .mode_bits(mode_bits),
        .ctrl_bits(ctrl_bits)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [1:0] off, input logic [31:0] val);
        @(negedge clk);
        host_sel = 1'b1; host_we = 1'b1; host_addr = off; host_wdata = val;
        @(negedge clk);
        host_sel = 1'b0; host_we = 1'b0;
    endtask

    task automatic hread(input logic [1:0] off, output logic [31:0] val);
        @(negedge clk);
        host_addr = off; host_sel = 1'b1; host_we = 1'b0;
        #1 val = host_rdata;
        host_sel = 1'b0;
    endtask

    // Called right after an address write; counts negedges with busy high.
    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic iwrite(input logic [4:0] idx, input logic [15:0] val);
        int n;
        hwrite(2'd0, {16'h0, val});
        hwrite(2'd1, {1'b1, 26'h0, idx});
        wait_idle(n);
    endtask

    task automatic iread(input logic [4:0] idx, output logic [31:0] val);
        int n;
        hwrite(2'd1, {1'b0, 26'h0, idx});
        wait_idle(n);
        hread(2'd0, val);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        hread(2'd0, v); chk("R1 data window", v, 0);
        hread(2'd2, v); chk("R1 status", v, 0);
        chk("R1 station", station_addr, 0);
        chk("R1 ctrl", ctrl_bits, 0);
        chk("R9 mode reset", mode_bits, 16'h0008);
    endtask

    task automatic t_latency_and_read;
        logic [31:0] v;
        int n;
        hwrite(2'd1, {1'b0, 26'h0, 5'd0});
        hread(2'd2, v); chk("R10 status busy", v, 1);
        hread(2'd1, v); chk("R10 addr readback", v, 32'h0000_0000);
        n = 2;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk("R2 busy cycles", n, LAT);
        hread(2'd0, v); chk("R4 read mode", v, 32'h0000_0008);
        hread(2'd2, v); chk("R10 status idle", v, 0);
    endtask

    task automatic t_write_commit;
        logic [31:0] v;
        int n;
        hwrite(2'd0, 32'hDEAD_BEEF);
        hread(2'd0, v); chk("R3 upper bits dropped", v, 32'h0000_BEEF);
        hwrite(2'd1, {1'b1, 26'h0, 5'd1});
        hread(2'd1, v); chk("R10 addr readback write", v, 32'h8000_0001);
        chk("R3 not yet committed", ctrl_bits, 0);
        wait_idle(n);
        chk("R3 committed", ctrl_bits, 16'hBEEF);
        iread(5'd1, v); chk("R4 read ctrl", v, 32'h0000_BEEF);
    endtask

    task automatic t_station;
        logic [31:0] v;
        iwrite(5'd4, 16'hACDE);
        iwrite(5'd5, 16'h4800);
        iwrite(5'd6, 16'h0080);
        chk("R8 station order", station_addr, 48'hACDE_4800_0080);
        iread(5'd5, v); chk("R8 read sta1", v, 32'h0000_4800);
        iwrite(5'd0, 16'h000B);
        chk("R9 mode write", mode_bits, 16'h000B);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] v;
        int n;
        hwrite(2'd1, {1'b0, 26'h0, 5'd4});
        hwrite(2'd0, 32'h0000_1234);
        hwrite(2'd1, {1'b1, 26'h0, 5'd1});
        n = 4;
        while (busy && n < 1000) begin n++; @(negedge clk); end
        chk("R5 no restart", n, LAT);
        chk("R5 ctrl untouched", ctrl_bits, 16'hBEEF);
        hread(2'd1, v); chk("R5 target kept", v, 32'h0000_0004);
        hread(2'd0, v); chk("R6 read result kept", v, 32'h0000_ACDE);
    endtask

    task automatic t_undefined;
        logic [31:0] v;
        iwrite(5'd9, 16'hFFFF);
        chk("R7 mode kept", mode_bits, 16'h000B);
        chk("R7 ctrl kept", ctrl_bits, 16'hBEEF);
        chk("R7 station kept", station_addr, 48'hACDE_4800_0080);
        iread(5'd9, v); chk("R7 undefined reads 0", v, 0);
        iread(5'd2, v); chk("R7 index 2 reads 0", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_latency_and_read;
        t_write_commit;
        t_station;
        t_busy_ignore;
        t_undefined;
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule